// File: doc/BRIEF.md
# Burst Address Counter with Programmable Wrap Boundary

This block produces the address for one port of a synchronous memory. A start address is captured from the external address bus on a load strobe. While the step enable is high, the captured address advances by one on every rising clock edge, so consecutive words can be accessed without driving a new address each cycle. When the step enable is low, the held address stays on the output and the memory keeps using it.

A boundary mask marks which low address bits take part in counting. The masked bits count up and wrap to zero. The remaining high bits keep the value they had when the address was loaded. With the mask at all ones, which is its reset value, the counter covers the whole address space and wraps from the top address back to zero. Each wrap sets a sticky wrap flag. That flag can be used as an interrupt for ring-buffer style transfers.

A synchronous counter clear has the highest priority, then load, then step. The live counter value or the mask can be placed on a readback bus. The mask is written from the same external address bus.

Top module: `burst_addr_gen`

## Requirements
- R1: After rst_n is released, addr_out is 0, the mask reads back as all ones and wrap_irq is 0.
- R2: When ads is high and cnt_clr is low at a rising edge, addr_out equals the addr_in value of that edge from the next cycle onward.
- R3: When cnt_en is high and both cnt_clr and ads are low at a rising edge, the address bits selected by the mask become their previous value plus one, modulo their span. The unselected bits do not change.
- R4: When cnt_clr, ads and cnt_en are all low at a rising edge, addr_out keeps its value.
- R5: When cnt_clr is high at a rising edge, addr_out becomes 0 and wrap_irq becomes 0, whatever ads and cnt_en are.
- R6: When ads and cnt_en are both high at the same edge, the load takes effect and no increment happens.
- R7: With the mask at all ones, stepping from the all-ones address gives address 0.
- R8: When mask_wr is high at a rising edge, the mask takes the value of addr_in. Otherwise the mask is unchanged. A step taken in the same edge uses the old mask. Mask values must be a run of ones starting at bit 0; the value 0 is allowed.
- R9: A step from an address whose masked bits are all ones sets wrap_irq in the next cycle. The flag then stays set while there is no clear source.
- R10: wrap_irq is cleared at an edge where irq_clr, ads or cnt_clr is high. If a wrap and irq_clr happen at the same edge, the flag is set.
- R11: rb_data shows the counter value when rb_sel is 0 and the mask when rb_sel is 1, in the same cycle (RB_REG = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clr | input | 1 | Synchronous counter clear, highest priority |
| ads | input | 1 | Load strobe: capture addr_in into the counter |
| cnt_en | input | 1 | Step enable |
| mask_wr | input | 1 | Write addr_in into the boundary mask |
| irq_clr | input | 1 | Clear pulse for the wrap flag |
| addr_in | input | ADDR_W | External start address, or mask data |
| rb_sel | input | 1 | Readback select: 0 counter, 1 mask |
| addr_out | output | ADDR_W | Current address for the memory |
| rb_data | output | ADDR_W | Readback bus |
| wrap_irq | output | 1 | Sticky wrap flag |

## Verification
The assertions assume that every mask written is a contiguous run of low ones. The in-RTL contiguity check flags any other value. To keep within this, the random stimulus builds each mask as 2^k - 1 for a random k from 0 to ADDR_W. The assertions also assume that all control inputs are low while rst_n is low, so no property sees a stale strobe in its first cycle after reset. The bench holds every input at zero during reset.

// File: rtl/bac_pkg.sv
package bac_pkg;
   // Counter action selected by the priority decoder
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_STEP  = 2'd1,
      ACT_LOAD  = 2'd2,
      ACT_CLEAR = 2'd3
   } bac_act_t;

   // Readback source select
   typedef enum logic {
      RB_COUNT = 1'b0,
      RB_MASK  = 1'b1
   } bac_rb_t;
endpackage

// File: rtl/bac_mask_reg.sv
module bac_mask_reg #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] din,
   output logic [W-1:0] mask_q
);
   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mask_q <= '1;
      else if (wr) mask_q <= din;
   end

   // R8: capture on write, keep otherwise
   assert_mask_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (mask_q == $past(din)));
   assert_mask_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(mask_q));
   // R8: written masks are a contiguous run of low ones
   assert_mask_contig_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((mask_q & (mask_q + ONE)) == '0));
endmodule

// File: rtl/bac_counter.sv
module bac_counter
   import bac_pkg::*;
#(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  bac_act_t     act,
   input  logic [W-1:0] din,
   input  logic [W-1:0] mask,
   output logic [W-1:0] cnt_q,
   output logic         wrap_ev
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] inc_full;
   logic [W-1:0] cnt_d;

   assign inc_full = cnt_q + ONE;
   // a step from masked-all-ones rolls the counting field over
   assign wrap_ev  = (act == ACT_STEP) && ((cnt_q & mask) == mask);

   always_comb begin
      unique case (act)
         ACT_CLEAR: cnt_d = '0;
         ACT_LOAD:  cnt_d = din;
         ACT_STEP:  cnt_d = (cnt_q & ~mask) | (inc_full & mask);
         default:   cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_LOAD) |=> (cnt_q == $past(din)));
   assert_step_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_STEP) |=>
         ((cnt_q & $past(mask)) == (W'($past(cnt_q) + ONE) & $past(mask))));
   assert_step_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_STEP) |=> ((cnt_q & ~$past(mask)) == ($past(cnt_q) & ~$past(mask))));
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_HOLD) |=> $stable(cnt_q));
   assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_CLEAR) |=> (cnt_q == '0));
   assert_full_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((act == ACT_STEP) && (mask == '1) && (cnt_q == '1)) |=> (cnt_q == '0));
endmodule

// File: rtl/bac_wrap_flag.sv
module bac_wrap_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic clr_sync,
   input  logic clr_pulse,
   output logic flag_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q <= 1'b0;
      else if (clr_sync)  flag_q <= 1'b0;
      else if (set_ev)    flag_q <= 1'b1;
      else if (clr_pulse) flag_q <= 1'b0;
   end

   assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ev && !clr_sync) |=> flag_q);
   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_ev && !clr_sync && !clr_pulse) |=> $stable(flag_q));
   assert_flag_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_sync || (clr_pulse && !set_ev)) |=> !flag_q);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import bac_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter bit RB_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_clr,
   input  logic              ads,
   input  logic              cnt_en,
   input  logic              mask_wr,
   input  logic              irq_clr,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              rb_sel,
   output logic [ADDR_W-1:0] addr_out,
   output logic [ADDR_W-1:0] rb_data,
   output logic              wrap_irq
);
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_width
      $error("burst_addr_gen: ADDR_W must lie in 1..32");
   end

   bac_act_t          act;
   logic [ADDR_W-1:0] mask_q;
   logic [ADDR_W-1:0] cnt_q;
   logic [ADDR_W-1:0] rb_mux;
   logic              wrap_ev;

   // priority: clear, then load, then step
   always_comb begin
      if (cnt_clr)     act = ACT_CLEAR;
      else if (ads)    act = ACT_LOAD;
      else if (cnt_en) act = ACT_STEP;
      else             act = ACT_HOLD;
   end

   bac_mask_reg #(.W(ADDR_W)) u_mask (
      .clk(clk), .rst_n(rst_n), .wr(mask_wr), .din(addr_in), .mask_q(mask_q));

   bac_counter #(.W(ADDR_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .act(act), .din(addr_in), .mask(mask_q),
      .cnt_q(cnt_q), .wrap_ev(wrap_ev));

   bac_wrap_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_ev(wrap_ev),
      .clr_sync((act == ACT_CLEAR) || (act == ACT_LOAD)),
      .clr_pulse(irq_clr), .flag_q(wrap_irq));

   assign addr_out = cnt_q;
   assign rb_mux   = (bac_rb_t'(rb_sel) == RB_MASK) ? mask_q : cnt_q;

   if (RB_REG) begin : g_rb_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rb_data <= '0;
         else        rb_data <= rb_mux;
      end
   end else begin : g_rb_comb
      assign rb_data = rb_mux;
   end

   assert_load_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ads && cnt_en && !cnt_clr) |=> (addr_out == $past(addr_in)));
   assert_clear_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> (!wrap_irq && (addr_out == '0)));
endmodule

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
   localparam int W = 12;
   localparam logic [W-1:0] ONES = '1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cnt_clr = 0, ads = 0, cnt_en = 0, mask_wr = 0, irq_clr = 0, rb_sel = 0;
   logic [W-1:0] addr_in = '0;
   logic [W-1:0] addr_out, rb_data;
   logic         wrap_irq;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // bench model state
   logic [W-1:0] m_cnt = '0;
   logic [W-1:0] m_mask = '1;
   logic         m_flag = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   burst_addr_gen #(.ADDR_W(W), .RB_REG(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .ads(ads), .cnt_en(cnt_en),
      .mask_wr(mask_wr), .irq_clr(irq_clr), .addr_in(addr_in), .rb_sel(rb_sel),
      .addr_out(addr_out), .rb_data(rb_data), .wrap_irq(wrap_irq));

   function automatic logic [W-1:0] advance(logic [W-1:0] c, logic [W-1:0] m);
      logic [W-1:0] low;
      low = (c & m) + W'(1);
      return (c & ~m) | (low & m);
   endfunction

   task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      check({tag, " addr_out"}, addr_out, m_cnt);
      check({tag, " wrap_irq"}, W'(wrap_irq), W'(m_flag));
      check({tag, " rb_data"}, rb_data, rb_sel ? m_mask : m_cnt);
   endtask

   // one clock: drive at negedge, update model, check at next negedge
   task automatic cyc(bit c_clr, bit c_ads, bit c_en, bit c_mwr, bit c_iclr,
                      logic [W-1:0] a, bit sel, string tag);
      cnt_clr = c_clr; ads = c_ads; cnt_en = c_en; mask_wr = c_mwr;
      irq_clr = c_iclr; addr_in = a; rb_sel = sel;
      if (c_clr) begin
         m_cnt = '0; m_flag = 1'b0;
      end else if (c_ads) begin
         m_cnt = a; m_flag = 1'b0;
      end else if (c_en) begin
         if ((m_cnt & m_mask) == m_mask) m_flag = 1'b1;
         else if (c_iclr) m_flag = 1'b0;
         m_cnt = advance(m_cnt, m_mask);
      end else if (c_iclr) begin
         m_flag = 1'b0;
      end
      if (c_mwr) m_mask = a;
      @(posedge clk);
      @(negedge clk);
      check_all(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog R1 actual=timeout expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state, mask visible as all ones
      rb_sel = 1'b1;
      #1 check_all("R1 reset");
      check("R1 mask", rb_data, ONES);

      cyc(0,1,0,0,0, 12'h123, 0, "R2 load");
      cyc(0,0,1,0,0, 12'h000, 0, "R3 step");
      cyc(0,0,1,0,0, 12'h000, 0, "R3 step");
      check("R3 value", addr_out, 12'h125);
      cyc(0,0,0,0,0, 12'h777, 0, "R4 hold");
      check("R4 value", addr_out, 12'h125);
      cyc(0,1,1,0,0, 12'h456, 0, "R6 load beats step");
      check("R6 value", addr_out, 12'h456);
      cyc(1,1,1,0,0, 12'h789, 0, "R5 clear beats all");
      check("R5 value", addr_out, 12'h000);
      // full-space wrap
      cyc(0,1,0,0,0, 12'hFFF, 0, "R7 load top");
      cyc(0,0,1,0,0, 12'h000, 0, "R7 R9 full wrap");
      check("R7 value", addr_out, 12'h000);
      check("R9 flag", W'(wrap_irq), W'(1));
      cyc(0,0,1,0,0, 12'h000, 0, "R9 sticky");
      cyc(0,0,0,0,1, 12'h000, 0, "R10 clear pulse");
      check("R10 cleared", W'(wrap_irq), W'(0));
      // mask 0x00F: low nibble counts, upper bits hold
      cyc(0,0,0,1,0, 12'h00F, 1, "R8 mask write");
      check("R8 readback", rb_data, 12'h00F);
      cyc(0,1,0,0,0, 12'hABE, 1, "R11 mask readback");
      cyc(0,0,1,0,0, 12'h000, 0, "R3 masked step");
      check("R3 masked", addr_out, 12'hABF);
      cyc(0,0,1,0,1, 12'h000, 0, "R10 set beats clear");
      check("R9 masked wrap", addr_out, 12'hAB0);
      check("R10 set wins", W'(wrap_irq), W'(1));
      cyc(0,1,0,0,0, 12'h3C5, 0, "R10 load clears");
      check("R10 load", W'(wrap_irq), W'(0));
      // step in the same edge as a mask write uses the old mask
      cyc(0,0,1,1,0, 12'h003, 0, "R8 old mask used");
      check("R8 old mask", addr_out, 12'h3C6);
      cyc(0,0,1,0,0, 12'h000, 0, "R3 two-bit field");
      cyc(0,0,1,0,0, 12'h000, 0, "R9 two-bit wrap");
      check("R9 two-bit", addr_out, 12'h3C4);
      cyc(1,0,0,0,0, 12'h000, 1, "R5 clear flag");
      check("R5 flag", W'(wrap_irq), W'(0));

      // constrained random mix (R3 R8 R9 R10 R11)
      for (int i = 0; i < 600; i++) begin
         bit r_clr, r_ads, r_en, r_mwr, r_iclr, r_sel;
         logic [W-1:0] a;
         r_clr  = ($urandom % 40) == 0;
         r_ads  = ($urandom % 8) == 0;
         r_en   = ($urandom % 4) != 0;
         r_mwr  = ($urandom % 20) == 0;
         r_iclr = ($urandom % 10) == 0;
         r_sel  = $urandom % 2;
         if (r_mwr) begin
            int k;
            k = $urandom % (W + 1);
            a = W'((33'd1 << k) - 33'd1);
         end else begin
            a = W'($urandom);
         end
         cyc(r_clr, r_ads, r_en, r_mwr, r_iclr, a, r_sel, "R3 R9 R10 R11 random");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule